// File: doc/BRIEF.md
# Strictly Non-Blocking Clos Path Allocator

This block chooses a middle-stage switch for every new connection through a three-stage Clos fabric. The fabric has M edge switches on the ingress side, each with N_PER ports and K uplinks. It has K middle switches, each M by M. It has M edge switches on the egress side, each with K downlinks and N_PER ports. A connection from ingress port `i` to egress port `o` must travel through one middle switch. That switch must not already carry traffic for the ingress edge switch of `i` or for the egress edge switch of `o`. Existing connections are never moved.

The block keeps two busy maps, one per edge stage, with one bit for each pair of edge switch and middle switch. It also keeps a table indexed by ingress port that records the middle switch and egress port of each live connection. A caller issues connect or release requests through a valid/ready handshake, at most one per cycle. The block answers on the following cycle with a grant carrying the middle index, a failure flag, or an error flag. When K is at least 2·N_PER−1, any connect between an idle input and an idle output is always granted.

Top module: `clos_path_alloc`

## Requirements
- R1: After reset is released, `rsp_valid` stays low and `req_ready` is high from the third clock edge on, with no connection live.
- R2: A request accepted at a clock edge produces exactly one response with `rsp_valid` high, visible right after the next edge. `rsp_valid` is low in every other cycle.
- R3: A granted connect (`req_op`=0) returns in `rsp_mid` the lowest-index middle switch that is free both at the ingress edge switch `req_in/N_PER` and at the egress edge switch `req_out/N_PER`.
- R4: A granted middle switch is never one already in use at either of those two edge switches, and no existing connection changes its middle switch.
- R5: With K ≥ 2·N_PER−1, a connect between an idle input port and an idle output port is always granted and never fails.
- R6: A connect whose input port or output port already carries a connection returns `rsp_err`. It changes no state, so a following connect picks the same middle switch it would have picked without it.
- R7: A release (`req_op`=1) of a connected input port returns `rsp_grant` with the middle index recorded for that port. It frees that middle switch at both edge switches and frees the output port.
- R8: A release of an input port that has no connection returns `rsp_err`.
- R9: When no middle switch is free at both edge switches, which is possible only with K < 2·N_PER−1, the connect returns `rsp_fail` and changes no state.
- R10: Every response carries exactly one of `rsp_grant`, `rsp_fail` and `rsp_err`, and `rsp_mid` is 0 unless the response is a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 = connect, 1 = release |
| req_in | input | PORT_W | Ingress port of the request |
| req_out | input | PORT_W | Egress port (connect only) |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request carried out |
| rsp_fail | output | 1 | No common free middle switch |
| rsp_err | output | 1 | Port state conflicts with the request |
| rsp_mid | output | MID_W | Middle switch assigned or released |

## Verification
The checker watches every cycle for the following properties. Each accepted request gets exactly one response one cycle later. Each response carries a single outcome flag. A granted connect's middle switch was free at both edge switches, and every lower index was busy at one of them. A failure never appears when K ≥ 2·N_PER−1.

Only the bench's scenarios can show the remaining behaviours. These are: a rejected connect leaves the allocation untouched; a release hands back the recorded index and lets a later connect reuse it; and an under-sized fabric (K=3) runs out of paths.

// File: rtl/clos_pkg.sv
package clos_pkg;
  typedef enum logic {
    OP_CONNECT = 1'b0,
    OP_RELEASE = 1'b1
  } clos_op_e;

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/clos_busy_map.sv
module clos_busy_map #(
  parameter int SWN   = 4,
  parameter int K     = 7,
  parameter int SW_W  = 2,
  parameter int MID_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [SW_W-1:0]    set_sw,
  input  logic [MID_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic [SW_W-1:0]    clr_sw,
  input  logic [MID_W-1:0]   clr_idx,
  input  logic [SW_W-1:0]    rd_sw,
  output logic [K-1:0]       rd_row,
  output logic [SWN*K-1:0]   all_rows
);

  for (genvar g = 0; g < SWN; g++) begin : g_row
    logic [K-1:0] row_q;
    logic [K-1:0] row_d;

    always_comb begin
      row_d = row_q;
      if (set_en && (set_sw == SW_W'(g))) row_d[set_idx] = 1'b1;
      if (clr_en && (clr_sw == SW_W'(g))) row_d[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_d;
    end

    assign all_rows[g*K +: K] = row_q;
  end

  assign rd_row = all_rows[rd_sw*K +: K];

endmodule

// File: rtl/clos_mid_pick.sv
module clos_mid_pick #(
  parameter int K     = 7,
  parameter int MID_W = 3
) (
  input  logic [K-1:0]     free_vec,
  output logic             found,
  output logic [MID_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int j = K - 1; j >= 0; j--) begin
      if (free_vec[j]) begin
        found = 1'b1;
        idx   = MID_W'(j);
      end
    end
  end

endmodule

// File: rtl/clos_port_table.sv
module clos_port_table #(
  parameter int NP     = 16,
  parameter int PORT_W = 4,
  parameter int MID_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_in,
  input  logic [PORT_W-1:0] wr_out,
  input  logic [MID_W-1:0]  wr_mid,
  input  logic              clr_en,
  input  logic [PORT_W-1:0] clr_in,
  input  logic [PORT_W-1:0] rd_in,
  input  logic [PORT_W-1:0] rd_outq,
  output logic              rd_used,
  output logic [MID_W-1:0]  rd_mid,
  output logic [PORT_W-1:0] rd_out,
  output logic              out_busy
);

  logic [NP-1:0]     in_used_q, in_used_d;
  logic [NP-1:0]     out_used_q, out_used_d;
  logic [MID_W-1:0]  mid_q [NP];
  logic [PORT_W-1:0] dst_q [NP];

  always_comb begin
    in_used_d  = in_used_q;
    out_used_d = out_used_q;
    if (wr_en) begin
      in_used_d[wr_in]   = 1'b1;
      out_used_d[wr_out] = 1'b1;
    end
    if (clr_en) begin
      in_used_d[clr_in]          = 1'b0;
      out_used_d[dst_q[clr_in]]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_used_q  <= '0;
      out_used_q <= '0;
    end else begin
      in_used_q  <= in_used_d;
      out_used_q <= out_used_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mid_q[wr_in] <= wr_mid;
      dst_q[wr_in] <= wr_out;
    end
  end

  assign rd_used  = in_used_q[rd_in];
  assign rd_mid   = mid_q[rd_in];
  assign rd_out   = dst_q[rd_in];
  assign out_busy = out_used_q[rd_outq];

endmodule

// File: rtl/clos_path_alloc.sv
module clos_path_alloc
  import clos_pkg::*;
#(
  parameter int N_PER = 4,
  parameter int M     = 4,
  parameter int K     = 7,
  localparam int NP     = N_PER * M,
  localparam int PORT_W = safe_clog2(NP),
  localparam int MID_W  = safe_clog2(K),
  localparam int SW_W   = safe_clog2(M)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [PORT_W-1:0] req_in,
  input  logic [PORT_W-1:0] req_out,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_fail,
  output logic              rsp_err,
  output logic [MID_W-1:0]  rsp_mid
);

  // reset synchronizer: assert asynchronously, release on the clock
  logic rs_a, rs_b, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  assign rst_s_n = rs_b;

  logic ready_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ready_q <= 1'b0;
    else          ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  // request decode
  clos_op_e          op;
  logic              accept, is_conn, is_rel;
  logic [SW_W-1:0]   in_sw, out_sw, old_out_sw;
  logic              tbl_used, tbl_out_busy;
  logic [MID_W-1:0]  tbl_mid;
  logic [PORT_W-1:0] tbl_out;
  logic [K-1:0]      s1_row, s3_row, free_vec;
  logic [M*K-1:0]    s1_flat, s3_flat;
  logic              pick_found;
  logic [MID_W-1:0]  pick_idx;
  logic              conn_err, do_set, do_clr;

  assign op         = clos_op_e'(req_op);
  assign accept     = req_valid && ready_q;
  assign is_conn    = accept && (op == OP_CONNECT);
  assign is_rel     = accept && (op == OP_RELEASE);
  assign in_sw      = SW_W'(req_in  / N_PER);
  assign out_sw     = SW_W'(req_out / N_PER);
  assign old_out_sw = SW_W'(tbl_out / N_PER);

  clos_port_table #(.NP(NP), .PORT_W(PORT_W), .MID_W(MID_W)) u_table (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(do_set), .wr_in(req_in), .wr_out(req_out), .wr_mid(pick_idx),
    .clr_en(do_clr), .clr_in(req_in),
    .rd_in(req_in), .rd_outq(req_out),
    .rd_used(tbl_used), .rd_mid(tbl_mid), .rd_out(tbl_out),
    .out_busy(tbl_out_busy)
  );

  clos_busy_map #(.SWN(M), .K(K), .SW_W(SW_W), .MID_W(MID_W)) u_ingress_map (
    .clk(clk), .rst_n(rst_s_n),
    .set_en(do_set), .set_sw(in_sw), .set_idx(pick_idx),
    .clr_en(do_clr), .clr_sw(in_sw), .clr_idx(tbl_mid),
    .rd_sw(in_sw), .rd_row(s1_row), .all_rows(s1_flat)
  );

  clos_busy_map #(.SWN(M), .K(K), .SW_W(SW_W), .MID_W(MID_W)) u_egress_map (
    .clk(clk), .rst_n(rst_s_n),
    .set_en(do_set), .set_sw(out_sw), .set_idx(pick_idx),
    .clr_en(do_clr), .clr_sw(old_out_sw), .clr_idx(tbl_mid),
    .rd_sw(out_sw), .rd_row(s3_row), .all_rows(s3_flat)
  );

  assign free_vec = ~s1_row & ~s3_row;

  clos_mid_pick #(.K(K), .MID_W(MID_W)) u_pick (
    .free_vec(free_vec), .found(pick_found), .idx(pick_idx)
  );

  assign conn_err = tbl_used || tbl_out_busy;
  assign do_set   = is_conn && !conn_err && pick_found;
  assign do_clr   = is_rel && tbl_used;

  // response: next-state and register
  logic             v_d, g_d, f_d, e_d;
  logic [MID_W-1:0] mid_d;

  always_comb begin
    v_d   = accept;
    g_d   = do_set || do_clr;
    f_d   = is_conn && !conn_err && !pick_found;
    e_d   = (is_conn && conn_err) || (is_rel && !tbl_used);
    mid_d = do_set ? pick_idx : (do_clr ? tbl_mid : '0);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_mid   <= '0;
    end else begin
      rsp_valid <= v_d;
      rsp_grant <= g_d;
      rsp_fail  <= f_d;
      rsp_err   <= e_d;
      rsp_mid   <= mid_d;
    end
  end

endmodule

// File: rtl/clos_path_alloc_chk.sv
module clos_path_alloc_chk #(
  parameter int N_PER  = 4,
  parameter int M      = 4,
  parameter int K      = 7,
  parameter int PORT_W = 4,
  parameter int MID_W  = 3
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_op,
  input logic [PORT_W-1:0] req_in,
  input logic [PORT_W-1:0] req_out,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic              rsp_fail,
  input logic              rsp_err,
  input logic [MID_W-1:0]  rsp_mid,
  input logic [M*K-1:0]    s1_flat,
  input logic [M*K-1:0]    s3_flat
);

  logic         acc;
  logic         cap_conn;
  logic [K-1:0] cap_s1, cap_s3;
  logic         seen_edge;
  logic [K-1:0] low_mask;

  assign acc      = req_valid && req_ready;
  assign low_mask = (K'(1) << rsp_mid) - K'(1);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cap_conn  <= 1'b0;
      cap_s1    <= '0;
      cap_s3    <= '0;
      seen_edge <= 1'b0;
    end else begin
      seen_edge <= 1'b1;
      if (acc) begin
        cap_conn <= !req_op;
        cap_s1   <= s1_flat[(req_in  / N_PER) * K +: K];
        cap_s3   <= s3_flat[(req_out / N_PER) * K +: K];
      end
    end
  end

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    seen_edge |-> req_ready);

  // R2
  one_rsp_per_req_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    acc |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !acc |=> !rsp_valid);

  // R10
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> ($countones({rsp_grant, rsp_fail, rsp_err}) == 1));

  // R4
  mid_free_both_ends_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && rsp_grant && cap_conn) |-> (!cap_s1[rsp_mid] && !cap_s3[rsp_mid]));

  // R3
  lowest_free_mid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && rsp_grant && cap_conn) |-> ((~(cap_s1 | cap_s3) & low_mask) == '0));

  // R5
  no_fail_when_sized_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> !(rsp_fail && (K >= 2 * N_PER - 1)));

endmodule

bind clos_path_alloc clos_path_alloc_chk #(
  .N_PER(N_PER), .M(M), .K(K), .PORT_W(PORT_W), .MID_W(MID_W)
) u_chk (
  .clk(clk), .rst_s_n(rst_s_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .req_in(req_in), .req_out(req_out),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fail(rsp_fail),
  .rsp_err(rsp_err), .rsp_mid(rsp_mid),
  .s1_flat(s1_flat), .s3_flat(s3_flat)
);

// File: tb/clos_path_alloc_test.sv
module clos_path_alloc_test;
  localparam int NPER = 4;
  localparam int MSW  = 4;
  localparam int KMID = 7;
  localparam int NP   = NPER * MSW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_op = 1'b0;
  logic [3:0] req_in = '0;
  logic [3:0] req_out = '0;
  logic       req_ready, rsp_valid, rsp_grant, rsp_fail, rsp_err;
  logic [2:0] rsp_mid;
  logic       s_ready, s_valid, s_grant, s_fail, s_err;
  logic [1:0] s_mid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  clos_path_alloc #(.N_PER(NPER), .M(MSW), .K(KMID)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_in(req_in), .req_out(req_out),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fail(rsp_fail),
    .rsp_err(rsp_err), .rsp_mid(rsp_mid)
  );

  // under-sized fabric for the out-of-paths case
  clos_path_alloc #(.N_PER(NPER), .M(MSW), .K(3)) uut_small (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(s_ready),
    .req_op(req_op), .req_in(req_in), .req_out(req_out),
    .rsp_valid(s_valid), .rsp_grant(s_grant), .rsp_fail(s_fail),
    .rsp_err(s_err), .rsp_mid(s_mid)
  );

  // reference model
  int m_used [NP];
  int m_mid  [NP];
  int m_dst  [NP];
  int m_obsy [NP];
  int m_s1   [MSW][KMID];
  int m_s3   [MSW][KMID];

  function automatic int pick_mid(input int isw, input int osw);
    for (int j = 0; j < KMID; j++)
      if (m_s1[isw][j] == 0 && m_s3[osw][j] == 0) return j;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(input bit op, input int pin, input int pout, input string req);
    int eg, ef, ee, em, p;
    eg = 0; ef = 0; ee = 0; em = 0;
    if (!op) begin
      if (m_used[pin] != 0 || m_obsy[pout] != 0) ee = 1;
      else begin
        p = pick_mid(pin / NPER, pout / NPER);
        if (p < 0) ef = 1;
        else begin
          eg = 1; em = p;
          m_used[pin] = 1; m_mid[pin] = p; m_dst[pin] = pout; m_obsy[pout] = 1;
          m_s1[pin / NPER][p] = 1; m_s3[pout / NPER][p] = 1;
        end
      end
    end else begin
      if (m_used[pin] == 0) ee = 1;
      else begin
        eg = 1; em = m_mid[pin];
        m_used[pin] = 0; m_obsy[m_dst[pin]] = 0;
        m_s1[pin / NPER][em] = 0; m_s3[m_dst[pin] / NPER][em] = 0;
      end
    end
    req_valid = 1'b1; req_op = op; req_in = 4'(pin); req_out = 4'(pout);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {req, " R2 valid"}, int'(rsp_valid), 1);
    check(rsp_grant == eg[0], {req, " grant"}, int'(rsp_grant), eg);
    check(rsp_fail == ef[0], {req, " fail"}, int'(rsp_fail), ef);
    check(rsp_err == ee[0], {req, " err"}, int'(rsp_err), ee);
    check(int'(rsp_mid) == em, {req, " R10 mid"}, int'(rsp_mid), em);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 idle", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int seed, a, b;
    seed = 32'h1d2c;
    void'($urandom(seed));
    for (int i = 0; i < NP; i++) begin
      m_used[i] = 0; m_mid[i] = 0; m_dst[i] = 0; m_obsy[i] = 0;
    end
    for (int s = 0; s < MSW; s++)
      for (int j = 0; j < KMID; j++) begin m_s1[s][j] = 0; m_s3[s][j] = 0; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    check(s_ready == 1'b1, "R1 small req_ready", int'(s_ready), 1);

    // R9: K=3 runs out; the sized fabric still grants (R5)
    do_req(1'b0, 0, 0,  "R3 c0");
    check(s_grant && s_mid == 2'd0, "R9 small c0", int'(s_mid), 0);
    do_req(1'b0, 1, 4,  "R3 c1");
    check(s_grant && s_mid == 2'd1, "R9 small c1", int'(s_mid), 1);
    do_req(1'b0, 2, 8,  "R3 c2");
    check(s_grant && s_mid == 2'd2, "R9 small c2", int'(s_mid), 2);
    do_req(1'b0, 3, 12, "R5 c3");
    check(s_fail == 1'b1, "R9 small fail", int'(s_fail), 1);
    check(s_grant == 1'b0 && s_mid == 2'd0, "R9 small no grant", int'(s_grant), 0);
    check(rsp_mid == 3'd3, "R5 sized grant mid", int'(rsp_mid), 3);
    idle_check();
    for (int i = 0; i < 4; i++) do_req(1'b1, i, 0, "R7 release");

    // R6: conflicting connects leave the map untouched
    do_req(1'b0, 5, 5, "R3 base");
    do_req(1'b0, 5, 6, "R6 busy input");
    do_req(1'b0, 6, 5, "R6 busy output");
    do_req(1'b0, 6, 6, "R6 after reject");
    check(rsp_mid == 3'd1, "R6 next mid", int'(rsp_mid), 1);
    // R7: release then reuse
    do_req(1'b1, 5, 0, "R7 release");
    check(rsp_mid == 3'd0, "R7 returned mid", int'(rsp_mid), 0);
    do_req(1'b0, 7, 7, "R7 reuse");
    check(rsp_mid == 3'd0, "R7 reused mid", int'(rsp_mid), 0);
    // R8
    do_req(1'b1, 9, 0, "R8 idle release");
    idle_check();

    // R4 crowding: full ingress switch 3 onto egress switch 0 and others
    for (int i = 12; i < 16; i++) do_req(1'b0, i, i - 12 + ((i == 12) ? 0 : 0), "R4 crowd");

    // constrained random mix
    for (int t = 0; t < 600; t++) begin
      a = int'($urandom_range(NP - 1));
      b = int'($urandom_range(NP - 1));
      if ($urandom_range(9) < 6) do_req(1'b0, a, b, "R4 rnd connect");
      else                       do_req(1'b1, a, 0, "R7 rnd release");
      if ($urandom_range(7) == 0) idle_check();
    end
    for (int i = 0; i < NP; i++)
      if (m_used[i] != 0) do_req(1'b1, i, 0, "R7 drain");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule